// File: doc/BRIEF.md
# Page Write Buffer with In-Page Wrap

This block sits between the byte receiver of a serial memory slave and its storage array. When a write transaction names its starting word address, the block records which page the address falls in and where inside that page the first byte lands. Each data byte that follows goes into a small staging store at the current in-page slot. After each byte, only the in-page part of the cursor steps forward. A long transfer therefore wraps back to the start of the same page and overwrites earlier bytes in the order they arrived.

Nothing reaches the array while bytes are still arriving. When the bus signals the end of the transaction, the block scans every slot of the page once, in ascending slot order. It issues one array write for each slot that actually received a byte, then pulses a done flag. At that moment it also publishes the address of the last byte accepted, so that a later current-address read can start one past it. A restart that is not an end of transaction throws the staged bytes away and writes nothing, which is what an address-only write ahead of a random read needs.

Top module: `page_wrbuf`

## Requirements
- R1: After reset, `arr_we` and `wr_done` are 0 and `last_ptr` is 0.
- R2: Every array write carries the page bits (`arr_addr[7:4]` with defaults) of the most recently loaded start address.
- R3: Byte k of a transaction (k counted from 0) is staged in slot (start + k) mod 16 of the start page. A start in the middle of a page wraps to slot 0 of the same page, not to the next page.
- R4: When more than 16 bytes arrive before commit, each slot holds the last byte written to it, so only the final 16 bytes survive.
- R5: `arr_we` is never high while bytes are being collected. It is high only during the commit scan.
- R6: At commit, exactly the slots that received at least one byte are written. The number of array writes equals the number of distinct slots filled.
- R7: A commit strobe sampled at clock edge E starts a scan that presents slot k between edge E+k and edge E+k+1, for k = 0..15 in ascending order. `wr_done` is high for exactly one cycle, between edges E+16 and E+17.
- R8: An abort strobe empties the staging store with no array write. A following commit produces no writes, and `last_ptr` keeps its value.
- R9: When `wr_done` rises after a scan that wrote at least one slot, `last_ptr` equals the full address of the last byte accepted ({page, slot of the final byte}).
- R10: Address-load, byte and commit strobes that arrive while a scan is running are ignored. They change neither the data written nor the contents staged for the next commit.
- R11: A commit with an empty staging store still completes the scan and pulses `wr_done`. It issues no array write and leaves `last_ptr` unchanged.
- R12: An address load starts a fresh transaction. Bytes staged before it that were never committed are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Strobe: latch `addr_in` as the start address of a new transaction |
| addr_in | input | 8 | Start word address |
| byte_valid | input | 1 | Strobe: one data byte is on `byte_in` |
| byte_in | input | 8 | Data byte to stage |
| commit | input | 1 | Strobe: end of transaction, write staged bytes to the array |
| abort | input | 1 | Strobe: restart without commit, discard staged bytes |
| arr_we | output | 1 | Array write enable (to the protection gate) |
| arr_addr | output | 8 | Array write address |
| arr_data | output | 8 | Array write data |
| wr_done | output | 1 | One-cycle pulse at the end of a commit scan |
| last_ptr | output | 8 | Address of the last byte committed |

## Verification
The bench goes after the in-page wrap by starting at the top slot of a page and by sending twenty bytes into one page. A design that carries into the page bits would write into the next page. A design that keeps the first bytes instead of the last would show stale data in overwritten slots. Abort, an empty commit and a fresh address load each follow staged bytes. A design that forgot to clear its valid mask would then write leftover bytes, and the bench counts every write it sees against the set of slots it expects. Strobes are also pushed in during a running scan: a design that accepted them would write foreign data, move the page, or leave entries behind for the next commit.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_st_e;
endpackage

// File: rtl/pwb_cursor.sv
// Holds the page of the current transaction, the next in-page slot and
// the full address of the last accepted byte.
module pwb_cursor #(
  parameter int AW = 8,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [AW-PB-1:0] page,
  output logic [PB-1:0] slot,
  output logic [AW-1:0] last_addr
);
  function automatic logic [PB-1:0] slot_after(input logic [PB-1:0] s);
    return s + 1'b1;  // carry out of the slot field is dropped: in-page wrap
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page      <= '0;
      slot      <= '0;
      last_addr <= '0;
    end else if (load) begin
      page <= load_addr[AW-1:PB];
      slot <= load_addr[PB-1:0];
    end else if (step) begin
      last_addr <= {page, slot};
      slot      <= slot_after(slot);
    end
  end
endmodule

// File: rtl/pwb_store.sv
// Staging store: one data register and one valid bit per slot.
module pwb_store #(
  parameter int DW = 8,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PB-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic [PB-1:0] rd_slot,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          any_valid
);
  localparam int DEPTH = 1 << PB;

  function automatic logic [DEPTH-1:0] slot_bit(input logic [PB-1:0] s);
    return DEPTH'(1) << s;
  endfunction

  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    ent_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (clear) vld_q <= '0;
    else if (wr)    vld_q <= vld_q | slot_bit(wr_slot);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr && !clear && wr_slot == PB'(e)) ent_q[e] <= wr_data;
    end
  end

  assign rd_data   = ent_q[rd_slot];
  assign rd_valid  = vld_q[rd_slot];
  assign any_valid = |vld_q;
endmodule

// File: rtl/pwb_scan.sv
// Commit sequencer: visits every slot once, then pulses done.
module pwb_scan #(
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [PB-1:0] idx,
  output logic          last,
  output logic          done
);
  import pwb_pkg::*;

  scan_st_e st_q;

  assign active = (st_q == SCAN_RUN);
  assign last   = active && (&idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SCAN_IDLE;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (!active) begin
        if (start) begin
          st_q <= SCAN_RUN;
          idx  <= '0;
        end
      end else begin
        idx <= idx + 1'b1;
        if (last) st_q <= SCAN_IDLE;
      end
    end
  end
endmodule

// File: rtl/page_wrbuf.sv
module page_wrbuf #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int PB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  input  logic          commit,
  input  logic          abort,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic          wr_done,
  output logic [AW-1:0] last_ptr
);
  // named internal events, also used by the bound checker
  logic          walk_active;
  logic [PB-1:0] walk_idx;
  logic          walk_last;
  logic [AW-PB-1:0] page;
  logic [PB-1:0] slot;
  logic [AW-1:0] last_addr;
  logic          ent_valid;
  logic [DW-1:0] ent_data;
  logic          any_valid;

  logic take_abort, take_load, take_byte, take_commit, wipe;

  assign take_abort  = abort && !walk_active;
  assign take_commit = commit && !walk_active && !take_abort;
  assign take_load   = addr_load && !walk_active && !take_abort && !commit;
  assign take_byte   = byte_valid && !walk_active && !take_abort && !commit && !addr_load;
  assign wipe        = take_abort || take_load || walk_last;

  pwb_cursor #(.AW(AW), .PB(PB)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .load(take_load), .load_addr(addr_in), .step(take_byte),
    .page(page), .slot(slot), .last_addr(last_addr)
  );

  pwb_store #(.DW(DW), .PB(PB)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr(take_byte), .wr_slot(slot), .wr_data(byte_in), .clear(wipe),
    .rd_slot(walk_idx), .rd_data(ent_data), .rd_valid(ent_valid),
    .any_valid(any_valid)
  );

  pwb_scan #(.PB(PB)) u_scan (
    .clk(clk), .rst_n(rst_n), .start(take_commit),
    .active(walk_active), .idx(walk_idx), .last(walk_last), .done(wr_done)
  );

  assign arr_we   = walk_active && ent_valid;
  assign arr_addr = {page, walk_idx};
  assign arr_data = ent_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                      last_ptr <= '0;
    else if (walk_last && any_valid) last_ptr <= last_addr;
  end
endmodule

// File: rtl/page_wrbuf_chk.sv
module page_wrbuf_chk #(
  parameter int AW = 8,
  parameter int PB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic          wr_done,
  input logic          walk_active,
  input logic [PB-1:0] walk_idx,
  input logic [AW-PB-1:0] page
);
  // R2
  page_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> arr_addr[AW-1:PB] == page);

  // R5
  scan_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_active) |-> $past(commit));

  // R7
  idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_active && $past(walk_active)) |-> walk_idx == $past(walk_idx) + 1'b1);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  // R7
  done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!walk_active && $past(walk_active)));

  // R10
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_active && $past(walk_active)) |-> $stable(page));
endmodule

bind page_wrbuf page_wrbuf_chk #(.AW(AW), .PB(PB)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .arr_we(arr_we),
  .arr_addr(arr_addr), .wr_done(wr_done), .walk_active(walk_active),
  .walk_idx(walk_idx), .page(page)
);

// File: tb/page_wrbuf_test.sv
module page_wrbuf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 0, byte_valid = 0, commit = 0, abort = 0;
  logic [7:0] addr_in = 0, byte_in = 0;
  logic arr_we, wr_done;
  logic [7:0] arr_addr, arr_data, last_ptr;

  always #2 clk = ~clk;  // 250 MHz

  page_wrbuf uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_in(byte_in), .commit(commit), .abort(abort),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .wr_done(wr_done), .last_ptr(last_ptr)
  );

  int total = 0, bad = 0;
  // bench model of the expected page contents
  logic [7:0] exp_mem [16];
  logic [15:0] exp_vld;
  logic [3:0] exp_page;
  bit in_walk = 0;
  int seen = 0, bad_wr = 0, stray = 0, last_lo = -1;

  // {start, byte count, expected writes, expected last address}
  localparam logic [31:0] VEC [5] = '{
    {8'h30, 8'd1,  8'd1,  8'h30},
    {8'h3C, 8'd6,  8'd6,  8'h31},
    {8'h72, 8'd20, 8'd16, 8'h75},
    {8'hA0, 8'd16, 8'd16, 8'hAF},
    {8'hFF, 8'd2,  8'd2,  8'hF0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (!in_walk) stray++;
      seen++;
      if (arr_addr[7:4] != exp_page || !exp_vld[arr_addr[3:0]] ||
          arr_data != exp_mem[arr_addr[3:0]]) bad_wr++;
      if (int'(arr_addr[3:0]) <= last_lo) bad_wr++;
      last_lo = int'(arr_addr[3:0]);
    end
  end

  task automatic do_load(input logic [7:0] a);
    @(posedge clk); #1 addr_load = 1; addr_in = a;
    @(posedge clk); #1 addr_load = 0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    @(posedge clk); #1 byte_valid = 1; byte_in = d;
    @(posedge clk); #1 byte_valid = 0;
  endtask

  task automatic do_abort();
    @(posedge clk); #1 abort = 1;
    @(posedge clk); #1 abort = 0;
  endtask

  task automatic model_clear(input logic [7:0] a);
    exp_vld = '0; exp_page = a[7:4];
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!wr_done && lat < 100);
  endtask

  task automatic do_commit(output int lat);
    seen = 0; bad_wr = 0; last_lo = -1; in_walk = 1;
    @(posedge clk); #1 commit = 1;
    @(posedge clk); #1 commit = 0;
    wait_done(lat);
    in_walk = 0;
  endtask

  initial begin
    #600000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] keep;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(arr_we == 0 && wr_done == 0, "R1", "outputs idle in reset", {arr_we, wr_done}, 0);
    chk(last_ptr == 0, "R1", "last_ptr after reset", last_ptr, 0);
    @(posedge clk); #1 rst_n = 1;

    // table walk: R2 R3 R4 R6 R7 R9
    for (int v = 0; v < 5; v++) begin
      logic [7:0] st, n, ew, el;
      {st, n, ew, el} = VEC[v];
      model_clear(st);
      do_load(st);
      for (int j = 0; j < int'(n); j++) begin
        logic [7:0] d;
        logic [3:0] s;
        d = 8'(int'(st) * 3 + j * 29 + v * 7 + 1);
        s = 4'(int'(st[3:0]) + j);
        exp_mem[s] = d; exp_vld[s] = 1'b1;
        do_byte(d);
      end
      chk(stray == 0, "R5", "no write while collecting", stray, 0);
      do_commit(lat);
      chk(seen == int'(ew), "R6", "write count", seen, ew);
      chk(bad_wr == 0, "R3", "page/slot/data/order of writes (R2 R4)", bad_wr, 0);
      chk(lat == 17, "R7", "commit to done latency", lat, 17);
      chk(last_ptr == el, "R9", "last_ptr after commit", last_ptr, el);
      @(negedge clk);
      chk(wr_done == 0, "R7", "done lasts one cycle", wr_done, 0);
    end

    // R8 abort discards
    keep = last_ptr;
    model_clear(8'h50);
    do_load(8'h50); do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    do_abort();
    do_commit(lat);
    chk(seen == 0, "R8", "writes after abort", seen, 0);
    chk(lat == 17, "R8", "done after abort commit", lat, 17);
    chk(last_ptr == keep, "R8", "last_ptr kept after abort", last_ptr, keep);

    // R12 new load discards uncommitted bytes
    model_clear(8'h48);
    do_load(8'h40); do_byte(8'hA1); do_byte(8'hA2);
    do_load(8'h48); exp_mem[8] = 8'h77; exp_vld[8] = 1'b1; do_byte(8'h77);
    do_commit(lat);
    chk(seen == 1 && bad_wr == 0, "R12", "only bytes after reload written", seen, 1);
    chk(last_ptr == 8'h48, "R12", "last_ptr after reload", last_ptr, 8'h48);

    // R10 strobes during scan are ignored
    model_clear(8'h20);
    do_load(8'h20); exp_mem[0] = 8'h5A; exp_vld[0] = 1'b1; do_byte(8'h5A);
    seen = 0; bad_wr = 0; last_lo = -1; in_walk = 1;
    @(posedge clk); #1 commit = 1;
    @(posedge clk); #1 commit = 0;
    @(posedge clk); #1 byte_valid = 1; byte_in = 8'h99; addr_load = 1; addr_in = 8'h60;
    repeat (3) @(posedge clk);
    #1 byte_valid = 0; addr_load = 0;
    @(posedge clk); #1 commit = 1;
    @(posedge clk); #1 commit = 0;
    wait_done(lat);
    in_walk = 0;
    chk(seen == 1 && bad_wr == 0, "R10", "scan unaffected by strobes", seen, 1);
    chk(last_ptr == 8'h20, "R10", "last_ptr unaffected", last_ptr, 8'h20);

    // R11 empty commit (also proves nothing was staged during the scan)
    do_commit(lat);
    chk(seen == 0, "R11", "empty commit writes nothing (R10)", seen, 0);
    chk(lat == 17, "R11", "empty commit still pulses done", lat, 17);
    chk(last_ptr == 8'h20, "R11", "last_ptr unchanged", last_ptr, 8'h20);
    chk(stray == 0, "R5", "no stray writes overall", stray, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule